// File: doc/BRIEF.md
# Secure Storage Command Frame Engine

This block handles whole command frames for a small secure storage element. It sits behind an I2C target that has already turned bus traffic into bytes. Command bytes arrive one at a time, and a strobe marks the last byte of a frame. Once the frame ends, the engine checks the trailing checksum and then decodes the command. It serves zone read and zone update requests against five on-chip storage zones, and it sends back a response frame as a byte stream with a valid/ready handshake.

Every command frame has the same layout. It starts with a one-byte command code, followed by three 16-bit big-endian fields (zone, offset, count). An update then carries its data bytes. The frame ends with a two-byte CRC-16/X-25, sent least-significant byte first. Every response starts with a status byte, followed by a 16-bit big-endian length, an optional payload and a closing CRC in the same form. Zones 0 to 3 hold constants that are loaded at reset and can never be modified. Zone 4 can be both read and written.

Top module: `sec_frame_proc`

## Requirements
- R1: A frame with fewer than three bytes, or whose trailing checksum does not match CRC-16/X-25 (reflected, polynomial 0x8408, start value 0xFFFF, result inverted, low byte sent first) over all earlier bytes, is answered with status 0x01. Such a frame is not decoded and changes no zone.
- R2: If the checksum is good and the command code is neither 0x05 (read) nor 0x06 (update), the response has status 0x04.
- R3: A read or update whose count field exceeds 512 is answered with status 0x06. This holds even when the zone or offset is also invalid.
- R4: A zone number above 4, or an offset plus count beyond the size of the zone, is answered with status 0x02.
- R5: A valid read (byte 0 = 0x05, bytes 1-2 zone, 3-4 offset, 5-6 count, all big-endian) returns status 0x00, followed by a length of count+2 and then the zone bytes starting at the offset, in ascending order.
- R6: A valid update to zone 4 (data bytes follow the count field) returns status 0x00 with length 0x0002. The data is stored at the given offset and can be seen by later reads.
- R7: An update that targets zones 0 to 3 returns status 0x02, and the zone keeps its contents.
- R8: Every response ends with the CRC-16/X-25 of all response bytes before it, low byte first.
- R9: After reset, byte i of zone z (z below 4) equals that zone's seed parameter plus i, modulo 256, and zone 4 reads as zeros. Default sizes are 16, 16, 16, 16 and 32 bytes, with seeds 0x10, 0x40, 0x80 and 0xC0.
- R10: Every non-zero status response carries no payload and reports a length of 0x0002.
- R11: A read frame that is not exactly 9 bytes long, or an update frame that is not exactly 9 plus count bytes long, is answered with status 0x02. The zone stays unchanged.
- R12: While a response is pending, the output byte is held stable until it is accepted. No input byte is accepted until the last response byte has been taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Command byte present |
| in_data | input | 8 | Command byte |
| in_last | input | 1 | Marks the final byte of a command frame |
| in_ready | output | 1 | Engine accepts command bytes |
| out_valid | output | 1 | Response byte present |
| out_data | output | 8 | Response byte |
| out_ready | input | 1 | Receiver takes the response byte |

## Verification
The assertions assume the feeding interface never presents a byte while in_ready is low, and that the receiver may stall the response for any number of cycles. The bench sends each byte only after it sees in_ready high at the falling edge. It throttles out_ready on alternate cycles for half of the table vectors, which exercises the hold property. The assertions also assume in_last comes with the final byte of every frame. The bench's frame builder always asserts in_last together with the last byte, including for the deliberately truncated and over-long frames.

// File: rtl/sec_frame_proc.sv
`timescale 1ns/1ps
module sec_frame_proc #(
  parameter int         Z0_BYTES = 16,
  parameter int         Z1_BYTES = 16,
  parameter int         Z2_BYTES = 16,
  parameter int         Z3_BYTES = 16,
  parameter int         Z4_BYTES = 32,
  parameter logic [7:0] Z0_SEED  = 8'h10,
  parameter logic [7:0] Z1_SEED  = 8'h40,
  parameter logic [7:0] Z2_SEED  = 8'h80,
  parameter logic [7:0] Z3_SEED  = 8'hC0,
  parameter int         MAX_LEN  = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  input  logic       out_ready
);

  localparam int B1 = Z0_BYTES;
  localparam int B2 = B1 + Z1_BYTES;
  localparam int B3 = B2 + Z2_BYTES;
  localparam int B4 = B3 + Z3_BYTES;
  localparam int MEM_N = B4 + Z4_BYTES;
  localparam int AW = $clog2(MEM_N);
  localparam int DW = (Z4_BYTES > 1) ? $clog2(Z4_BYTES) : 1;
  localparam logic [15:0] RESIDUE = 16'hF0B8;

  typedef enum logic [1:0] {S_RX, S_CHK, S_WR, S_TX} st_t;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  function automatic logic [7:0] init_byte(input int j);
    if (j < B1)      return Z0_SEED + 8'(j);
    else if (j < B2) return Z1_SEED + 8'(j - B1);
    else if (j < B3) return Z2_SEED + 8'(j - B2);
    else if (j < B4) return Z3_SEED + 8'(j - B3);
    else             return 8'h00;
  endfunction

  st_t         st;
  logic [15:0] rx_cnt, rx_crc, tx_crc;
  logic [7:0]  cmd, status;
  logic [15:0] zone, off, len, plen, idx;
  logic [7:0]  mem  [MEM_N];
  logic [7:0]  dbuf [Z4_BYTES];

  logic [16:0] zsize;
  logic [15:0] zbase;
  always_comb begin
    case (zone)
      16'd0:   begin zsize = 17'(Z0_BYTES); zbase = 16'd0;     end
      16'd1:   begin zsize = 17'(Z1_BYTES); zbase = 16'(B1);   end
      16'd2:   begin zsize = 17'(Z2_BYTES); zbase = 16'(B2);   end
      16'd3:   begin zsize = 17'(Z3_BYTES); zbase = 16'(B3);   end
      16'd4:   begin zsize = 17'(Z4_BYTES); zbase = 16'(B4);   end
      default: begin zsize = 17'd0;         zbase = 16'd0;     end
    endcase
  end

  wire        end_ok  = ({1'b0, off} + {1'b0, len}) <= zsize;
  wire [15:0] exp_cnt = 16'd9 + ((cmd == 8'h06) ? len : 16'd0);
  wire        crc_ok  = (rx_cnt >= 16'd3) && (rx_crc == RESIDUE);

  logic [7:0] chk_status;
  always_comb begin
    if (!crc_ok)                                  chk_status = 8'h01;
    else if (cmd != 8'h05 && cmd != 8'h06)        chk_status = 8'h04;
    else if (int'(len) > MAX_LEN)                 chk_status = 8'h06;
    else if (zone > 16'd4 || !end_ok || rx_cnt != exp_cnt ||
             (cmd == 8'h06 && zone != 16'd4))     chk_status = 8'h02;
    else                                          chk_status = 8'h00;
  end

  wire [15:0] tx_total = plen + 16'd5;
  wire [15:0] rlen     = plen + 16'd2;
  wire [AW-1:0] rd_addr = AW'(zbase + off + (idx - 16'd3));
  wire [AW-1:0] wr_addr = AW'(16'(B4) + off + idx);
  wire [DW-1:0] buf_rd  = DW'(idx);
  wire          rx_take = in_valid && in_ready;
  wire          tx_take = out_valid && out_ready;

  assign in_ready  = (st == S_RX);
  assign out_valid = (st == S_TX);

  always_comb begin
    if (idx == 16'd0)                 out_data = status;
    else if (idx == 16'd1)            out_data = rlen[15:8];
    else if (idx == 16'd2)            out_data = rlen[7:0];
    else if (idx == tx_total - 16'd2) out_data = ~tx_crc[7:0];
    else if (idx == tx_total - 16'd1) out_data = ~tx_crc[15:8];
    else if (int'(rd_addr) < MEM_N)   out_data = mem[rd_addr];
    else                              out_data = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rx_take && rx_cnt >= 16'd7 && (rx_cnt - 16'd7) < 16'(Z4_BYTES))
      dbuf[DW'(rx_cnt - 16'd7)] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_RX;
      rx_cnt <= 16'd0;
      rx_crc <= 16'hFFFF;
      tx_crc <= 16'hFFFF;
      cmd    <= 8'h00;
      status <= 8'h00;
      zone   <= 16'd0;
      off    <= 16'd0;
      len    <= 16'd0;
      plen   <= 16'd0;
      idx    <= 16'd0;
      for (int j = 0; j < MEM_N; j++) mem[j] <= init_byte(j);
    end else begin
      case (st)
        S_RX: if (rx_take) begin
          rx_crc <= crc_step(rx_crc, in_data);
          if (rx_cnt != 16'hFFFF) rx_cnt <= rx_cnt + 16'd1;
          case (rx_cnt)
            16'd0:   cmd        <= in_data;
            16'd1:   zone[15:8] <= in_data;
            16'd2:   zone[7:0]  <= in_data;
            16'd3:   off[15:8]  <= in_data;
            16'd4:   off[7:0]   <= in_data;
            16'd5:   len[15:8]  <= in_data;
            16'd6:   len[7:0]   <= in_data;
            default: ;
          endcase
          if (in_last) st <= S_CHK;
        end
        S_CHK: begin
          status <= chk_status;
          plen   <= (chk_status == 8'h00 && cmd == 8'h05) ? len : 16'd0;
          tx_crc <= 16'hFFFF;
          idx    <= 16'd0;
          st     <= (chk_status == 8'h00 && cmd == 8'h06 && len != 16'd0) ? S_WR : S_TX;
        end
        S_WR: begin
          mem[wr_addr] <= dbuf[buf_rd];
          if (idx == len - 16'd1) begin
            idx <= 16'd0;
            st  <= S_TX;
          end else idx <= idx + 16'd1;
        end
        S_TX: if (tx_take) begin
          if (idx < tx_total - 16'd2) tx_crc <= crc_step(tx_crc, out_data);
          if (idx == tx_total - 16'd1) begin
            idx    <= 16'd0;
            rx_cnt <= 16'd0;
            rx_crc <= 16'hFFFF;
            st     <= S_RX;
          end else idx <= idx + 16'd1;
        end
        default: st <= S_RX;
      endcase
    end
  end

  assert_hold_byte_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_status_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && idx == 16'd0 |-> (out_data == 8'h00 || out_data == 8'h01 ||
      out_data == 8'h02 || out_data == 8'h04 || out_data == 8'h06));

  assert_err_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && idx == 16'd2 && status != 8'h00 |-> out_data == 8'h02);

  assert_len_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && status == 8'h00 |-> int'(len) <= MAX_LEN);

  assert_write_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_WR |-> zone == 16'd4 && cmd == 8'h06 && crc_ok);

  for (genvar j = 0; j < B4; j++) begin : g_locked
    assert_locked_zone_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(mem[j]));
  end

endmodule

// File: tb/test_sec_frame_proc.sv
`timescale 1ns/1ps
module test_sec_frame_proc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, out_valid;
  logic [7:0] out_data;

  always #10 clk = ~clk;

  sec_frame_proc i_sec_frame_proc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready));

  int checks = 0, fails = 0;
  logic [7:0] fr [0:63];
  int fr_n;
  logic [7:0] rsp [0:63];
  int rsp_n;
  logic [7:0] mdl [0:4][0:31];
  int zsz [0:4] = '{16, 16, 16, 16, 32};

  // {cmd, zone, off, len, expected status, corrupt}
  localparam int NV = 20;
  localparam logic [64:0] VEC [NV] = '{
    {8'h05, 16'd0, 16'd0,  16'd4,   8'h00, 1'b0},
    {8'h05, 16'd3, 16'd2,  16'd8,   8'h00, 1'b0},
    {8'h05, 16'd4, 16'd0,  16'd32,  8'h00, 1'b0},
    {8'h05, 16'd1, 16'd15, 16'd1,   8'h00, 1'b0},
    {8'h05, 16'd1, 16'd15, 16'd2,   8'h02, 1'b0},
    {8'h05, 16'd5, 16'd0,  16'd1,   8'h02, 1'b0},
    {8'h05, 16'd0, 16'd0,  16'd513, 8'h06, 1'b0},
    {8'h05, 16'd4, 16'd0,  16'd512, 8'h02, 1'b0},
    {8'h02, 16'd0, 16'd0,  16'd4,   8'h04, 1'b0},
    {8'h05, 16'd0, 16'd0,  16'd4,   8'h01, 1'b1},
    {8'h05, 16'd2, 16'd0,  16'd0,   8'h00, 1'b0},
    {8'h06, 16'd2, 16'd0,  16'd2,   8'h02, 1'b0},
    {8'h06, 16'd4, 16'd4,  16'd3,   8'h00, 1'b0},
    {8'h05, 16'd4, 16'd0,  16'd8,   8'h00, 1'b0},
    {8'h06, 16'd4, 16'd0,  16'd513, 8'h06, 1'b0},
    {8'h05, 16'd2, 16'd0,  16'd4,   8'h00, 1'b0},
    {8'h06, 16'd4, 16'd30, 16'd2,   8'h00, 1'b0},
    {8'h06, 16'd4, 16'd31, 16'd2,   8'h02, 1'b0},
    {8'h05, 16'd4, 16'd24, 16'd8,   8'h00, 1'b0},
    {8'h13, 16'd0, 16'd0,  16'd0,   8'h04, 1'b0}
  };

  function automatic logic [15:0] step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  function automatic logic [7:0] dbyte(input int i);
    return 8'h5A ^ 8'(i * 7);
  endfunction

  function automatic string tag_of(input logic [7:0] s);
    case (s)
      8'h01: return "R1";
      8'h04: return "R2";
      8'h06: return "R3";
      8'h02: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic seal(input int nb, input bit bad);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < nb; i++) c = step(c, fr[i]);
    c = ~c;
    fr[nb]     = c[7:0];
    fr[nb + 1] = c[15:8] ^ {7'd0, bad};
    fr_n = nb + 2;
  endtask

  task automatic build(input logic [7:0] cmd, input logic [15:0] zone, input logic [15:0] off,
                       input logic [15:0] len, input int nd, input bit bad);
    fr[0] = cmd;
    fr[1] = zone[15:8]; fr[2] = zone[7:0];
    fr[3] = off[15:8];  fr[4] = off[7:0];
    fr[5] = len[15:8];  fr[6] = len[7:0];
    for (int i = 0; i < nd; i++) fr[7 + i] = dbyte(i);
    seal(7 + nd, bad);
  endtask

  task automatic send();
    for (int i = 0; i < fr_n; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data  = fr[i];
      in_last  = (i == fr_n - 1);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic recv(input bit stall);
    int guard = 0;
    int total = 64;
    bit held = 1'b0;
    logic [7:0] hv = 8'h00;
    bit seen_busy = 1'b0;
    rsp_n = 0;
    while (rsp_n < total && guard < 3000) begin
      @(negedge clk);
      guard++;
      if (held) check(out_valid && out_data == hv, "R12 hold", int'(out_data), int'(hv));
      if (out_valid && !seen_busy) begin
        seen_busy = 1'b1;
        check(!in_ready, "R12 input blocked", int'(in_ready), 0);
      end
      out_ready = stall ? guard[0] : 1'b1;
      held = out_valid && !out_ready;
      hv = out_data;
      if (out_valid && out_ready && rsp_n < 64) begin
        rsp[rsp_n] = out_data;
        rsp_n++;
        if (rsp_n == 3) total = 3 + int'({rsp[1], rsp[2]});
      end
      @(posedge clk);
    end
    @(negedge clk);
    out_ready = 1'b0;
    check(rsp_n == total, "R12 response complete", rsp_n, total);
  endtask

  task automatic verify(input logic [7:0] cmd, input logic [15:0] zone, input logic [15:0] off,
                        input logic [15:0] len, input logic [7:0] exp, input string tag);
    int pl;
    logic [15:0] c = 16'hFFFF;
    pl = (exp == 8'h00 && cmd == 8'h05) ? int'(len) : 0;
    if (rsp_n < 5) begin
      check(1'b0, tag, rsp_n, 5);
      return;
    end
    check(rsp[0] == exp, tag, int'(rsp[0]), int'(exp));
    check(int'({rsp[1], rsp[2]}) == pl + 2, (exp == 8'h00) ? "R5 length" : "R10 error length",
          int'({rsp[1], rsp[2]}), pl + 2);
    if (rsp[0] == exp && exp == 8'h00 && cmd == 8'h05)
      for (int i = 0; i < pl; i++)
        check(rsp[3 + i] == mdl[zone][int'(off) + i], "R5 payload", int'(rsp[3 + i]),
              int'(mdl[zone][int'(off) + i]));
    for (int i = 0; i < rsp_n - 2; i++) c = step(c, rsp[i]);
    c = ~c;
    check({rsp[rsp_n - 1], rsp[rsp_n - 2]} == c, "R8 response crc",
          int'({rsp[rsp_n - 1], rsp[rsp_n - 2]}), int'(c));
  endtask

  task automatic read_back(input int z, input int off, input int len, input string tag);
    build(8'h05, 16'(z), 16'(off), 16'(len), 0, 1'b0);
    send();
    recv(1'b0);
    verify(8'h05, 16'(z), 16'(off), 16'(len), 8'h00, tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #4000000;
    checks++;
    fails++;
    $display("FAIL watchdog R12 actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [64:0] v;
    int nd;
    for (int z = 0; z < 5; z++)
      for (int i = 0; i < 32; i++)
        mdl[z][i] = (z < 4) ? (8'h10 + 8'(z * 8'h30) + (z == 3 ? 8'h00 : 8'h00) + 8'(i)) : 8'h00;
    mdl[0][0] = 8'h10;
    for (int i = 0; i < 32; i++) begin
      mdl[0][i] = 8'h10 + 8'(i);
      mdl[1][i] = 8'h40 + 8'(i);
      mdl[2][i] = 8'h80 + 8'(i);
      mdl[3][i] = 8'hC0 + 8'(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R12 reset in_ready", int'(in_ready), 1);
    check(out_valid == 1'b0, "R12 reset out_valid", int'(out_valid), 0);

    for (int z = 0; z < 5; z++) read_back(z, 0, zsz[z], "R9 reset contents");

    for (int n = 0; n < NV; n++) begin
      v = VEC[n];
      nd = (v[64:57] == 8'h06 && v[24:9] <= 16'd32) ? int'(v[24:9]) : 0;
      build(v[64:57], v[56:41], v[40:25], v[24:9], nd, v[0]);
      send();
      recv(n[0]);
      verify(v[64:57], v[56:41], v[40:25], v[24:9], v[8:1],
             (v[64:57] == 8'h06 && v[56:41] != 16'd4) ? "R7 locked zone" :
             (v[64:57] == 8'h06 && v[8:1] == 8'h00) ? "R6 update" : tag_of(v[8:1]));
      if (v[64:57] == 8'h06 && v[8:1] == 8'h00)
        for (int i = 0; i < nd; i++) mdl[4][int'(v[40:25]) + i] = dbyte(i);
    end

    // R11: read frame one byte short
    build(8'h05, 16'd0, 16'd0, 16'd4, 0, 1'b0);
    seal(6, 1'b0);
    send(); recv(1'b0);
    verify(8'h05, 16'd0, 16'd0, 16'd4, 8'h02, "R11 short read");

    // R11: read frame with one extra byte
    build(8'h05, 16'd3, 16'd0, 16'd2, 1, 1'b0);
    send(); recv(1'b1);
    verify(8'h05, 16'd3, 16'd0, 16'd2, 8'h02, "R11 long read");

    // R11: update with fewer data bytes than counted
    build(8'h06, 16'd4, 16'd0, 16'd4, 2, 1'b0);
    send(); recv(1'b0);
    verify(8'h06, 16'd4, 16'd0, 16'd4, 8'h02, "R11 short update");
    read_back(4, 0, 8, "R11 zone unchanged");

    // R1: corrupted update must not write
    build(8'h06, 16'd4, 16'd8, 16'd2, 2, 1'b1);
    send(); recv(1'b1);
    verify(8'h06, 16'd4, 16'd8, 16'd2, 8'h01, "R1 bad crc update");
    read_back(4, 8, 2, "R1 zone unchanged");

    // R1: two-byte frame is too short to carry a checksum
    fr[0] = 8'h05; fr[1] = 8'h00; fr_n = 2;
    send(); recv(1'b0);
    verify(8'h05, 16'd0, 16'd0, 16'd0, 8'h01, "R1 runt frame");

    // R7: locked zones still read as seeded
    for (int z = 0; z < 4; z++) read_back(z, 0, zsz[z], "R7 locked contents");
    read_back(4, 0, 32, "R6 zone 4 final");

    summary();
    $finish;
  end
endmodule